// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects interrupt requests from two groups of level-sensitive sources and drives a single request line to the processor. The primary group has 40 sources. The secondary group has 32 sources, and any enabled pending secondary request shows up as primary source 0. Each source has a latched pending bit and an enable bit. Software changes the enables through separate set and clear registers, and clears pending bits through clear registers. All of these registers act only on the bit positions written as 1.

To avoid scanning bits, software reads a priority index register. It returns the primary source that wins among those that are both enabled and pending. The order comes from a per-source mapping table: the source with the smallest mapped channel number wins.

When the index reads 0, software clears primary pending bit 0 and then reads the secondary status register. It serves the secondary sources starting from the lowest set bit. Register access uses a plain 32-bit bus with a 12-bit byte address. Writes take effect at the clock edge, and read data appears one cycle after the read strobe.

Top module: `intc_cascade`

## Requirements
- R1: After reset all enable and pending bits are 0, `cpu_irq` is low, the index register reads 0, and mapping entry i reads back i.
- R2: A primary or secondary source that is high at a clock edge sets its pending bit. The bit stays set after the input falls, until it is cleared. A clear written while the input is still high leaves the bit set.
- R3: The enable-set registers (primary at 0x20, secondary at 0x90), the enable-clear registers (0x30, 0x98) and the pending-clear registers (0x10, 0x88) change only the bits written as 1. Primary sources 0-31 sit in bits 31:0 at the base offset. Sources 32-39 sit in bits 7:0 at base+4.
- R4: `cpu_irq` is high exactly when some primary source is both enabled and pending. Primary source 0 is the cascade.
- R5: Bits [5:0] of the register at 0x40 give the index of the enabled pending primary source with the lowest mapped channel number. On a tie in channel number, the lower source index wins. The register reads 0 when no such source exists or when source 0 wins.
- R6: Mapping entry i is at 0x200+4*i and holds a 6-bit channel number in bits [5:0]. It is readable, and writing it changes the priority order of R5.
- R7: Any secondary source that is both enabled and pending sets primary pending bit 0. Clearing that bit has no effect while such a secondary source remains.
- R8: The register at 0x80 reads the secondary pending bits ANDed with the secondary enables.
- R9: Reads of the set and clear registers, and of unmapped addresses, return 0. Read data is valid in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_irq | input | 39 | Primary request inputs for sources 39..1 |
| sec_irq | input | 32 | Secondary request inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench targets these corner cases:
- **Single-source sweeps.** Every primary source and every secondary source is pulsed on its own. A bank split on the wrong word would show up here as a wrong index for sources 32-39, and a bad cascade path would leave `cpu_irq` low for secondary events.
- **Cascade clear while a secondary request remains.** A design that lets bit 0 drop here loses the secondary request.
- **Clear while the input is still high.** This catches an edge-triggered or clear-dominant pending bit.
- **Remapped and duplicated channel numbers.** These expose a search that ignores the table or breaks ties toward the higher source.
- **Long pseudo-random mix of operations.** This run is checked against an arithmetic model. It catches zero bits in set or clear writes that disturb neighbouring bits.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_PEND_CLR  = 12'h010;
    localparam logic [ADDR_W-1:0] A_EN_SET    = 12'h020;
    localparam logic [ADDR_W-1:0] A_EN_CLR    = 12'h030;
    localparam logic [ADDR_W-1:0] A_WIN_IDX   = 12'h040;
    localparam logic [ADDR_W-1:0] A_SEC_STAT  = 12'h080;
    localparam logic [ADDR_W-1:0] A_SEC_PCLR  = 12'h088;
    localparam logic [ADDR_W-1:0] A_SEC_ESET  = 12'h090;
    localparam logic [ADDR_W-1:0] A_SEC_ECLR  = 12'h098;
    localparam logic [ADDR_W-1:0] A_CHAN_BASE = 12'h200;

    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_WIN,
        RSEL_SSTAT,
        RSEL_CHAN
    } rd_sel_e;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] en_set,
    input  logic [W-1:0] en_clr,
    input  logic [W-1:0] pend_clr,
    output logic [W-1:0] pend,
    output logic [W-1:0] en
);

    logic [W-1:0] pend_q;
    logic [W-1:0] en_q;

    // Level sources dominate the clear: a held input re-latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | src;
            en_q   <= (en_q | en_set) & ~en_clr;
        end
    end

    assign pend = pend_q;
    assign en   = en_q;

    AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|src) |=> ((pend_q & $past(src)) == $past(src))) // R2
        else $error("source high did not set pending");

    AST_PEND_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |=> ((($past(pend_q) & ~pend_q) & ~$past(pend_clr)) == '0)) // R3
        else $error("pending bit fell without a clear");

    AST_EN_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (~(en_set | en_clr) != '0) |=> (((en_q ^ $past(en_q)) & ~($past(en_set) | $past(en_clr))) == '0)) // R3
        else $error("enable bit changed without a write of 1");

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 40,
    parameter int CW = 6,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*CW-1:0] chan_flat,
    output logic [IW-1:0]   win,
    output logic            any
);

    logic [CW:0]   best_ch;
    logic [IW-1:0] best_ix;

    // Strict less-than keeps the lower source on equal channel numbers.
    always_comb begin
        best_ch = {1'b1, {CW{1'b0}}};
        best_ix = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && ({1'b0, chan_flat[i*CW +: CW]} < best_ch)) begin
                best_ch = {1'b0, chan_flat[i*CW +: CW]};
                best_ix = IW'(i);
            end
        end
    end

    assign win = best_ix;
    assign any = |req;

    AST_WIN_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[win]) // R5
        else $error("winner is not a requester");

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (win == '0)) // R5
        else $error("index nonzero with no requester");

endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
    import intc_pkg::*;
#(
    parameter int NUM_PRI = 40,
    parameter int NUM_SEC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PRI-1:1]  pri_irq,
    input  logic [NUM_SEC-1:0]  sec_irq,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                cpu_irq
);

    localparam int CW = $clog2(NUM_PRI);
    localparam int IW = $clog2(NUM_PRI);

    logic [NUM_PRI-1:0] p_set, p_clr, p_pclr, pri_pend, pri_en, pri_act;
    logic [NUM_SEC-1:0] s_set, s_clr, s_pclr, sec_pend, sec_en, sec_act;
    logic               sec_any;
    logic [CW-1:0]      chan_q [NUM_PRI];
    logic [NUM_PRI*CW-1:0] chan_flat;
    logic [IW-1:0]      win_ix;
    logic               win_any;
    rd_sel_e            rsel;
    logic [CW-1:0]      chan_rd;
    logic [DATA_W-1:0]  rd_val;
    logic [DATA_W-1:0]  rdata_q;

    // Primary write decode: bit b lives in word b/32 at base + 4*(b/32).
    always_comb begin
        p_set  = '0;
        p_clr  = '0;
        p_pclr = '0;
        for (int b = 0; b < NUM_PRI; b++) begin
            if (bus_wr && bus_addr == A_EN_SET + ADDR_W'(4 * (b / 32)))
                p_set[b] = bus_wdata[b % 32];
            if (bus_wr && bus_addr == A_EN_CLR + ADDR_W'(4 * (b / 32)))
                p_clr[b] = bus_wdata[b % 32];
            if (bus_wr && bus_addr == A_PEND_CLR + ADDR_W'(4 * (b / 32)))
                p_pclr[b] = bus_wdata[b % 32];
        end
    end

    assign s_set  = (bus_wr && bus_addr == A_SEC_ESET) ? bus_wdata[NUM_SEC-1:0] : '0;
    assign s_clr  = (bus_wr && bus_addr == A_SEC_ECLR) ? bus_wdata[NUM_SEC-1:0] : '0;
    assign s_pclr = (bus_wr && bus_addr == A_SEC_PCLR) ? bus_wdata[NUM_SEC-1:0] : '0;

    irq_src_bank #(.W(NUM_SEC)) u_sec (
        .clk(clk), .rst_n(rst_n), .src(sec_irq),
        .en_set(s_set), .en_clr(s_clr), .pend_clr(s_pclr),
        .pend(sec_pend), .en(sec_en)
    );

    assign sec_act = sec_pend & sec_en;
    assign sec_any = |sec_act;

    irq_src_bank #(.W(NUM_PRI)) u_pri (
        .clk(clk), .rst_n(rst_n), .src({pri_irq, sec_any}),
        .en_set(p_set), .en_clr(p_clr), .pend_clr(p_pclr),
        .pend(pri_pend), .en(pri_en)
    );

    assign pri_act = pri_pend & pri_en;
    assign cpu_irq = |pri_act;

    // Channel mapping table, identity after reset.
    for (genvar g = 0; g < NUM_PRI; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chan_q[g] <= CW'(g);
            else if (bus_wr && bus_addr == A_CHAN_BASE + ADDR_W'(4 * g))
                chan_q[g] <= bus_wdata[CW-1:0];
        end
        assign chan_flat[g*CW +: CW] = chan_q[g];
    end

    irq_prio_pick #(.N(NUM_PRI), .CW(CW)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(pri_act), .chan_flat(chan_flat),
        .win(win_ix), .any(win_any)
    );

    // Read select and mux.
    always_comb begin
        rsel    = RSEL_ZERO;
        chan_rd = '0;
        if (bus_addr == A_WIN_IDX)
            rsel = RSEL_WIN;
        else if (bus_addr == A_SEC_STAT)
            rsel = RSEL_SSTAT;
        for (int i = 0; i < NUM_PRI; i++) begin
            if (bus_addr == A_CHAN_BASE + ADDR_W'(4 * i)) begin
                rsel    = RSEL_CHAN;
                chan_rd = chan_q[i];
            end
        end
    end

    always_comb begin
        unique case (rsel)
            RSEL_WIN:   rd_val = DATA_W'(win_ix);
            RSEL_SSTAT: rd_val = DATA_W'(sec_act);
            RSEL_CHAN:  rd_val = DATA_W'(chan_rd);
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

    AST_CASCADE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_any |=> pri_pend[0]) // R7
        else $error("secondary request did not reach primary 0");

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_EN_SET || bus_addr == A_SEC_ECLR)) |=> (bus_rdata == '0)) // R9
        else $error("write-only register read nonzero");

    AST_IRQ_HAS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> win_any) // R4
        else $error("irq without an active source");

endmodule

// File: tb/tb_intc_cascade.sv
`timescale 1ns/1ps
module tb_intc_cascade;

    localparam int NP = 40;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:1] pri_irq = '0;
    logic [NS-1:0] sec_irq = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NP-1:0] pend_m = '0, en_m = '0;
    logic [NS-1:0] spend_m = '0, sen_m = '0;
    logic [5:0]    map_m [NP];
    logic [31:0]   lfsr = 32'h1ACE_5EED;

    always #2.5 clk = ~clk;

    intc_cascade dut (
        .clk(clk), .rst_n(rst_n), .pri_irq(pri_irq), .sec_irq(sec_irq),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] nxt();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    function automatic int exp_idx();
        int best = 0;
        int bc = 64;
        for (int i = 0; i < NP; i++)
            if (pend_m[i] && en_m[i] && int'(map_m[i]) < bc) begin
                bc = int'(map_m[i]);
                best = i;
            end
        return best;
    endfunction

    task automatic settle();
        if (|(spend_m & sen_m)) pend_m[0] = 1'b1;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            12'h010: pend_m[31:0]  = pend_m[31:0] & ~d;
            12'h014: pend_m[39:32] = pend_m[39:32] & ~d[7:0];
            12'h020: en_m[31:0]    = en_m[31:0] | d;
            12'h024: en_m[39:32]   = en_m[39:32] | d[7:0];
            12'h030: en_m[31:0]    = en_m[31:0] & ~d;
            12'h034: en_m[39:32]   = en_m[39:32] & ~d[7:0];
            12'h088: spend_m       = spend_m & ~d;
            12'h090: sen_m         = sen_m | d;
            12'h098: sen_m         = sen_m & ~d;
            default: if (a >= 12'h200 && a < 12'h2A0) map_m[(a - 12'h200) >> 2] = d[5:0];
        endcase
        if (a == 12'h010 && d[0]) pend_m[0] = |(spend_m & sen_m);
        settle();
        @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_pri(logic [NP-1:0] v);
        @(negedge clk);
        pri_irq = v[NP-1:1];
        @(negedge clk);
        pri_irq = '0;
        pend_m = pend_m | {v[NP-1:1], 1'b0};
        settle();
        @(negedge clk);
    endtask

    task automatic pulse_sec(logic [NS-1:0] v);
        @(negedge clk);
        sec_irq = v;
        @(negedge clk);
        sec_irq = '0;
        spend_m = spend_m | v;
        settle();
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        rd(12'h040, d);
        chk({tag, " R5 idx"}, d, 32'(exp_idx()));
        rd(12'h080, d);
        chk({tag, " R8 sstat"}, d, 32'(spend_m & sen_m));
        chk({tag, " R4 irq"}, 32'(cpu_irq), 32'(|(pend_m & en_m)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        for (int i = 0; i < NP; i++) map_m[i] = 6'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(cpu_irq), 0);
        rd(12'h040, d); chk("R1 idx", d, 0);
        rd(12'h080, d); chk("R1 sstat", d, 0);
        for (int i = 0; i < NP; i++) begin
            rd(12'(12'h200 + 4 * i), d);
            chk("R1 R6 map identity", d, 32'(i));
        end
        // R9 write-only and unmapped reads
        foreach (d[k]) begin end
        rd(12'h010, d); chk("R9 pclr", d, 0);
        rd(12'h024, d); chk("R9 eset hi", d, 0);
        rd(12'h030, d); chk("R9 eclr", d, 0);
        rd(12'h088, d); chk("R9 spclr", d, 0);
        rd(12'h090, d); chk("R9 seset", d, 0);
        rd(12'h098, d); chk("R9 seclr", d, 0);
        rd(12'h3F0, d); chk("R9 unmapped", d, 0);

        // Unenabled source raises nothing (R4)
        pulse_pri(40'h1 << 12);
        chk("R4 disabled irq", 32'(cpu_irq), 0);
        wr(12'h010, 32'h1 << 12);

        // R3 R5 single-source sweep across both banks
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h024, 32'h0000_00FF);
        for (int s = 1; s < NP; s++) begin
            pulse_pri(40'h1 << s);
            rd(12'h040, d); chk("R5 single idx", d, 32'(s));
            chk("R4 single irq", 32'(cpu_irq), 1);
            if (s < 32) wr(12'h010, 32'h1 << s);
            else        wr(12'h014, 32'h1 << (s - 32));
            rd(12'h040, d); chk("R3 cleared idx", d, 0);
            chk("R3 cleared irq", 32'(cpu_irq), 0);
        end

        // R2 level hold through a clear
        @(negedge clk); pri_irq[7] = 1'b1;
        @(negedge clk);
        wr(12'h010, 32'h80);
        rd(12'h040, d); chk("R2 held after clear", d, 7);
        pri_irq[7] = 1'b0;
        pend_m[7] = 1'b1;
        wr(12'h010, 32'h80);
        rd(12'h040, d); chk("R2 released clear", d, 0);

        // R3 zero bits leave neighbours alone
        wr(12'h030, 32'h20);
        pulse_pri((40'h1 << 5) | (40'h1 << 9));
        check_all("R3 partial disable");
        wr(12'h010, 32'h0000_0200);
        check_all("R3 partial clear");
        wr(12'h010, 32'h20);
        wr(12'h020, 32'h20);

        // R6 reversed map, then tie
        for (int i = 0; i < NP; i++) wr(12'(12'h200 + 4 * i), 32'(NP - 1 - i));
        rd(12'h208, d); chk("R6 readback", d, 37);
        pulse_pri((40'h1 << 3) | (40'h1 << 30));
        rd(12'h040, d); chk("R6 reversed winner", d, 30);
        wr(12'h200 + 4 * 3, 32'(NP - 1 - 30));
        rd(12'h040, d); chk("R5 tie lower source", d, 3);
        wr(12'h010, 32'hFFFF_FFFF);
        for (int i = 0; i < NP; i++) wr(12'(12'h200 + 4 * i), 32'(i));

        // R7 R8 cascade sweep
        wr(12'h090, 32'hFFFF_FFFF);
        for (int k = 0; k < NS; k++) begin
            pulse_sec(32'h1 << k);
            rd(12'h080, d); chk("R8 sstat single", d, 32'h1 << k);
            rd(12'h040, d); chk("R5 cascade idx", d, 0);
            chk("R7 cascade irq", 32'(cpu_irq), 1);
            wr(12'h010, 32'h1);
            chk("R7 clear blocked", 32'(cpu_irq), 1);
            wr(12'h088, 32'h1 << k);
            wr(12'h010, 32'h1);
            chk("R7 cascade released", 32'(cpu_irq), 0);
        end

        // Pseudo-random mix against the model (R2 R3 R4 R5 R6 R7 R8)
        for (int it = 0; it < 500; it++) begin
            logic [31:0] r, a, b;
            r = nxt(); a = nxt(); b = nxt();
            case (r % 8)
                0, 1: pulse_pri({a[7:0] & b[7:0], a & b & nxt()});
                2:    pulse_sec(a & b);
                3:    wr((r[8] ? 12'h020 : 12'h030) + (r[9] ? 12'h4 : 12'h0), a & b);
                4:    wr(12'h010 + (r[9] ? 12'h4 : 12'h0), a | b);
                5:    wr(r[8] ? 12'h090 : (r[9] ? 12'h098 : 12'h088), a & b);
                6:    wr(12'(12'h200 + 4 * (a % NP)), 32'(b[5:0]));
                default: wr(12'h010, 32'h1);
            endcase
            check_all("mix");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule